// File: doc/BRIEF.md
# Receive FIFO Threshold Release Control

This block sits next to a receive frame FIFO. It watches bytes as the MAC side writes them and decides when the DMA may start reading the current frame. Each byte write is one cycle with `wr_en` high. The write that carries the last byte of a frame also has `wr_eof` high. The block counts the bytes of the frame in progress and raises `req` once enough of the frame is stored to start the transfer.

There are two modes. In cut-through mode, a 2-bit select picks one of four byte thresholds. The request rises when the stored part of the frame becomes strictly larger than that threshold. A frame that ends before reaching the threshold is released on its final write. In store-and-forward mode the select has no effect, and the request rises only on the final write of the frame. The select and the mode bit are captured on the first byte of each frame. The request stays high until the DMA pulses `dma_done` to report that the whole frame has been drained.

Top module: `rx_release_ctrl`

## Requirements
- R1: In cut-through mode, `thr_sel` selects the byte threshold as follows: 2'b01 gives 32, 2'b00 gives 64, 2'b10 gives 96 and 2'b11 gives 128.
- R2: In cut-through mode, `req` is high in the cycle after the write that makes the frame's byte count strictly greater than the threshold. A count equal to the threshold, with the frame not yet ended, leaves `req` low.
- R3: A frame whose final write (`wr_eof` high) comes at or below the threshold is released by that final write, so `req` is high in the next cycle.
- R4: With `sf_mode` high, `thr_sel` is ignored. `req` rises only in the cycle after the write that carries `wr_eof`.
- R5: `frame_cnt` increases by one for each write without `wr_eof`. It is 0 in the cycle after a write with `wr_eof`, and it keeps its value in any cycle without a write.
- R6: `thr_sel` and `sf_mode` are sampled on the first write of a frame. Changing them later in the frame does not change when that frame is released.
- R7: Once `req` is high it stays high until `dma_done` is pulsed, and it is low in the next cycle. If a release and `dma_done` fall in the same cycle, `req` stays high.
- R8: Each frame is released at most once. After its request has been acknowledged, later bytes of the same frame, including its final byte, do not raise `req` again.
- R9: After reset, `req` is low and `frame_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One byte written into the FIFO this cycle |
| wr_eof | input | 1 | The byte written this cycle ends the frame |
| thr_sel | input | 2 | Cut-through threshold select |
| sf_mode | input | 1 | Store-and-forward mode |
| dma_done | input | 1 | DMA has drained the released frame |
| req | output | 1 | Transfer request toward the DMA |
| frame_cnt | output | CW | Bytes of the current frame stored so far |

## Verification
The release of a new frame and the DMA acknowledgement of an earlier one can happen in the same cycle. The bench makes this happen by leaving one frame's request unacknowledged and then pulsing `dma_done` exactly on the write that crosses the next frame's threshold. It then expects `req` to stay high through that cycle and to fall only after a later acknowledgement on its own. A second test acknowledges a frame in the middle of its data. It expects `req` to fall and to stay low through the rest of that frame, including its end-of-frame write.

// File: rtl/rx_release_ctrl.sv
module rx_release_ctrl #(
  parameter int MAX_LEN = 2048,
  parameter int THR_00  = 64,
  parameter int THR_01  = 32,
  parameter int THR_10  = 96,
  parameter int THR_11  = 128,
  localparam int CW     = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_eof,
  input  logic [1:0]    thr_sel,
  input  logic          sf_mode,
  input  logic          dma_done,
  output logic          req,
  output logic [CW-1:0] frame_cnt
);

  logic [CW-1:0] cnt_q;
  logic [1:0]    sel_q;
  logic          sf_q;
  logic          sent_q;
  logic          req_q;

  logic          first;
  logic [1:0]    sel_eff;
  logic          sf_eff;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] thr_val;
  logic          rel;

  assign first   = (cnt_q == '0);
  assign sel_eff = first ? thr_sel : sel_q;
  assign sf_eff  = first ? sf_mode : sf_q;
  assign cnt_nxt = (cnt_q == CW'(MAX_LEN)) ? cnt_q : cnt_q + CW'(1);

  always_comb begin
    case (sel_eff)
      2'b00:   thr_val = CW'(THR_00);
      2'b01:   thr_val = CW'(THR_01);
      2'b10:   thr_val = CW'(THR_10);
      default: thr_val = CW'(THR_11);
    endcase
  end

  assign rel = wr_en && !sent_q && (wr_eof || (!sf_eff && cnt_nxt > thr_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sel_q  <= '0;
      sf_q   <= 1'b0;
      sent_q <= 1'b0;
    end else if (wr_en) begin
      if (first) begin
        sel_q <= thr_sel;
        sf_q  <= sf_mode;
      end
      cnt_q  <= wr_eof ? '0 : cnt_nxt;
      sent_q <= wr_eof ? 1'b0 : (sent_q | rel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= rel | (req_q & ~dma_done);
  end

  assign req       = req_q;
  assign frame_cnt = cnt_q;

endmodule

module rx_release_ctrl_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_eof,
  input logic          dma_done,
  input logic          sf_eff,
  input logic          req,
  input logic [CW-1:0] frame_cnt
);

  a_r2_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(wr_en));

  a_r4_sf_waits_eof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) && $past(sf_eff) |-> $past(wr_eof));

  a_r5_eof_zeroes_count: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_eof |=> frame_cnt == '0);

  a_r5_idle_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(frame_cnt));

  a_r7_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done && !wr_en |=> !req);

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    req && !dma_done |=> req);

endmodule

bind rx_release_ctrl rx_release_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_eof(wr_eof),
  .dma_done(dma_done), .sf_eff(sf_eff), .req(req), .frame_cnt(frame_cnt)
);

// File: tb/test_rx_release_ctrl.sv
module test_rx_release_ctrl;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_eof = 1'b0, sf_mode = 1'b0, dma_done = 1'b0;
  logic [1:0]    thr_sel = 2'b00;
  logic          req;
  logic [CW-1:0] frame_cnt;

  int n_run = 0, n_fail = 0;
  logic exp_req = 1'b0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  rx_release_ctrl i_rx_release_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_eof(wr_eof),
    .thr_sel(thr_sel), .sf_mode(sf_mode), .dma_done(dma_done),
    .req(req), .frame_cnt(frame_cnt)
  );

  // {thr_sel, sf_mode, length, write index that releases}
  localparam logic [26:0] TBL [0:8] = '{
    {2'b00, 1'b0, 12'd100, 12'd65 },  // R1 R2 64
    {2'b01, 1'b0, 12'd40,  12'd33 },  // R1 R2 32
    {2'b10, 1'b0, 12'd200, 12'd97 },  // R1 R2 96
    {2'b11, 1'b0, 12'd200, 12'd129},  // R1 R2 128
    {2'b11, 1'b0, 12'd128, 12'd128},  // R3 ends at threshold
    {2'b01, 1'b0, 12'd10,  12'd10 },  // R3 short frame
    {2'b00, 1'b1, 12'd150, 12'd150},  // R4
    {2'b01, 1'b1, 12'd20,  12'd20 },  // R4
    {2'b10, 1'b0, 12'd1,   12'd1  }   // R3 single byte
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Called and returns at a negedge.
  task automatic run_frame(input logic [1:0] ts, input logic sf, input int len,
                           input int rel_at, input int ack_at, input logic scr,
                           input int gap_at, input string rq);
    for (int i = 1; i <= len; i++) begin
      wr_en    = 1'b1;
      wr_eof   = (i == len);
      thr_sel  = (scr && i > 1) ? ~ts : ts;
      sf_mode  = (scr && i > 1) ? ~sf : sf;
      dma_done = (i == ack_at);
      @(negedge clk);
      if (i == rel_at)      exp_req = 1'b1;
      else if (i == ack_at) exp_req = 1'b0;
      check({rq, " req"}, 32'(req), 32'(exp_req));
      check("R5 count", 32'(frame_cnt), (i == len) ? 0 : i);
      if (i == gap_at) begin
        wr_en = 1'b0; wr_eof = 1'b0; dma_done = 1'b0;
        @(negedge clk);
        check("R5 idle hold", 32'(frame_cnt), i);
        check("R7 idle req", 32'(req), 32'(exp_req));
      end
    end
    wr_en = 1'b0; wr_eof = 1'b0; dma_done = 1'b0;
  endtask

  task automatic ack;
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    exp_req  = 1'b0;
    check("R7 ack clears", 32'(req), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R9 reset req", 32'(req), 0);
    check("R9 reset count", 32'(frame_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (TBL[k]) begin
      run_frame(TBL[k][26:25], TBL[k][24], int'(TBL[k][23:12]), int'(TBL[k][11:0]),
                0, 1'b0, 0, "R1-table R2/R3/R4");
      ack();
    end

    // R6: settings change after first byte are ignored
    run_frame(2'b01, 1'b0, 50, 33, 0, 1'b1, 0, "R6 midframe change");
    ack();
    run_frame(2'b00, 1'b1, 70, 70, 0, 1'b1, 0, "R6 sf kept");
    ack();

    // R5: gap inside a frame
    run_frame(2'b00, 1'b0, 80, 65, 0, 1'b0, 20, "R5 gap frame");
    ack();

    // R7: release and ack in the same cycle
    run_frame(2'b10, 1'b0, 100, 97, 0, 1'b0, 0, "R7 pending");
    run_frame(2'b01, 1'b0, 40, 33, 33, 1'b0, 0, "R7 overlap");
    check("R7 still high", 32'(req), 1);
    ack();

    // R8: acknowledged mid-frame, no second release
    run_frame(2'b01, 1'b0, 60, 33, 40, 1'b0, 0, "R8 single release");
    check("R8 after eof", 32'(req), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule